// File: doc/BRIEF.md
# Fracturable Integer Multiplier

This tile multiplies two 36-bit unsigned operands and returns a 72-bit product, with no clock anywhere on the path. A small static configuration lets the same hardware serve as one wide 36×36 multiplier or as two independent 18-bit sections. Each section can itself be a single 18×18 multiplier or a pair of 9×9 multipliers, chosen separately for each section.

Internally the operands are cut into four 9-bit lanes each. A four-by-four array of lane partial products is formed once. The configuration only decides which partial products are summed, and at which offsets. Operand and product bits sit at fixed positions for every mode, so surrounding logic packs narrow operands into the lanes and reads narrow results back from fixed bit ranges.

Top module: `mfr_tile`

## Requirements
- R1: With `cfg_split` = 0 (whole mode), `prod` equals the unsigned 72-bit product of `opa` and `opb`.
- R2: In whole mode both bits of `cfg_quarter` have no effect on `prod`.
- R3: With `cfg_split` = 1, section s (s = 0, 1) reads only `opa[18s+17:18s]` and `opb[18s+17:18s]` and drives only `prod[36s+35:36s]`.
- R4: In split mode, `cfg_quarter[s]` = 0 makes section s one unsigned 18×18 multiplier that fills its 36 output bits.
- R5: In split mode, `cfg_quarter[s]` = 1 makes section s two 9×9 multipliers: slice j (j = 0, 1) multiplies section operand bits [9j+8:9j] and drives section output bits [18j+17:18j].
- R6: The two sections are configured independently, and no carry or product bit crosses from one section's output range into the other's, even with all-ones operands.
- R7: The output is a purely combinational function of the inputs, and a zero operand gives a zero product in every mode.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 36 | Multiplicand, four 9-bit lanes |
| opb | input | 36 | Multiplier, four 9-bit lanes |
| cfg_split | input | 1 | 0 = one 36×36 multiplier, 1 = two 18-bit sections |
| cfg_quarter | input | 2 | Bit s: 0 = section s is 18×18, 1 = section s is dual 9×9 |
| prod | output | 72 | Product bits, assembled according to the mode |

## Verification
The hardest case to reach from the ports is a carry that would leak across a section or slice boundary. That leak only shows up when the partial sums are at their largest, and random operands seldom get there. The stimulus therefore applies all-ones operands in each of the eight configuration combinations, alongside random operands. It also runs whole-mode vectors with both quarter bits toggled, because those bits must then have no effect.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
   typedef enum logic {
      SEC_WIDE = 1'b0,
      SEC_DUAL = 1'b1
   } sec_mode_e;

   localparam int LANES = 4;
endpackage

// File: rtl/mfr_pp_array.sv
module mfr_pp_array #(
   parameter int QW = 9,
   parameter int NL = 4
) (
   input  logic [NL*QW-1:0] a,
   input  logic [NL*QW-1:0] b,
   output logic [2*QW-1:0]  pp [NL][NL]
);
   genvar gi, gj;
   generate
      for (gi = 0; gi < NL; gi++) begin : g_row
         for (gj = 0; gj < NL; gj++) begin : g_col
            assign pp[gi][gj] = (2*QW)'(a[gi*QW +: QW]) * (2*QW)'(b[gj*QW +: QW]);
         end
      end
   endgenerate
endmodule

// File: rtl/mfr_section.sv
module mfr_section
   import mfr_pkg::*;
#(
   parameter int QW = 9
) (
   input  logic [2*QW-1:0] p_ll,
   input  logic [2*QW-1:0] p_lh,
   input  logic [2*QW-1:0] p_hl,
   input  logic [2*QW-1:0] p_hh,
   input  sec_mode_e       mode,
   output logic [4*QW-1:0] y
);
   localparam int SW = 4*QW;

   logic [SW-1:0] wide_sum;
   logic [SW-1:0] dual_cat;

   always_comb begin
      wide_sum = SW'(p_ll)
               + (SW'(p_lh) << QW)
               + (SW'(p_hl) << QW)
               + (SW'(p_hh) << (2*QW));
      dual_cat = {p_hh, p_ll};
      y = (mode == SEC_DUAL) ? dual_cat : wide_sum;
   end
endmodule

// File: rtl/mfr_tile.sv
module mfr_tile
   import mfr_pkg::*;
#(
   parameter int QW = 9
) (
   input  logic [4*QW-1:0] opa,
   input  logic [4*QW-1:0] opb,
   input  logic            cfg_split,
   input  logic [1:0]      cfg_quarter,
   output logic [8*QW-1:0] prod
);
   localparam int NL = LANES;
   localparam int FW = NL*QW;
   localparam int PW = 2*FW;
   localparam int SW = 2*FW/2;

   generate
      if (QW < 2) begin : g_bad_width
         $error("mfr_tile: lane width QW must be at least 2");
      end
   endgenerate

   logic [2*QW-1:0] pp [NL][NL];
   logic [PW-1:0]   whole_sum;
   logic [SW-1:0]   sec_y [2];

   mfr_pp_array #(.QW(QW), .NL(NL)) u_pp (
      .a  (opa),
      .b  (opb),
      .pp (pp)
   );

   always_comb begin
      whole_sum = '0;
      for (int i = 0; i < NL; i++) begin
         for (int j = 0; j < NL; j++) begin
            whole_sum = whole_sum + (PW'(pp[i][j]) << (QW*(i+j)));
         end
      end
   end

   genvar gs;
   generate
      for (gs = 0; gs < 2; gs++) begin : g_sec
         mfr_section #(.QW(QW)) u_sec (
            .p_ll (pp[2*gs][2*gs]),
            .p_lh (pp[2*gs][2*gs+1]),
            .p_hl (pp[2*gs+1][2*gs]),
            .p_hh (pp[2*gs+1][2*gs+1]),
            .mode (sec_mode_e'(cfg_quarter[gs])),
            .y    (sec_y[gs])
         );
      end
   endgenerate

   assign prod = cfg_split ? {sec_y[1], sec_y[0]} : whole_sum;
endmodule

// File: rtl/mfr_tile_chk.sv
module mfr_tile_chk #(
   parameter int QW = 9
) (
   input logic [4*QW-1:0] opa,
   input logic [4*QW-1:0] opb,
   input logic            cfg_split,
   input logic [1:0]      cfg_quarter,
   input logic [8*QW-1:0] prod
);
   localparam int FW = 4*QW;
   localparam int PW = 8*QW;
   localparam int HW = 2*QW;

   always_comb begin
      if (!cfg_split) begin
         AST_WHOLE_PROD: assert (prod == PW'(opa) * PW'(opb)); // R1
      end else begin
         for (int s = 0; s < 2; s++) begin
            if (!cfg_quarter[s]) begin
               AST_HALF_PROD: assert (prod[s*FW +: FW] ==
                  FW'(opa[s*HW +: HW]) * FW'(opb[s*HW +: HW])); // R4
            end else begin
               for (int j = 0; j < 2; j++) begin
                  AST_QUARTER_PROD: assert (prod[s*FW + j*HW +: HW] ==
                     HW'(opa[s*HW + j*QW +: QW]) * HW'(opb[s*HW + j*QW +: QW])); // R5
               end
            end
         end
      end
      if (opa == '0 || opb == '0) begin
         AST_ZERO_OPND: assert (prod == '0); // R7
      end
   end
endmodule

bind mfr_tile mfr_tile_chk #(.QW(QW)) u_chk (.*);

// File: tb/sim_mfr_tile.sv
module sim_mfr_tile;
   localparam int QW = 9;
   localparam int FW = 4*QW;
   localparam int PW = 8*QW;
   localparam int HW = 2*QW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [FW-1:0] opa = '0;
   logic [FW-1:0] opb = '0;
   logic          cfg_split = 1'b0;
   logic [1:0]    cfg_quarter = 2'b00;
   logic [PW-1:0] prod;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   mfr_tile #(.QW(QW)) u0 (
      .opa         (opa),
      .opb         (opb),
      .cfg_split   (cfg_split),
      .cfg_quarter (cfg_quarter),
      .prod        (prod)
   );

   function automatic logic [PW-1:0] ref_prod(input logic [FW-1:0] a, input logic [FW-1:0] b,
                                              input logic sp, input logic [1:0] q);
      logic [PW-1:0] r;
      r = '0;
      if (!sp) begin
         r = PW'(a) * PW'(b);
      end else begin
         for (int s = 0; s < 2; s++) begin
            logic [HW-1:0] sa, sb;
            sa = a[s*HW +: HW];
            sb = b[s*HW +: HW];
            if (!q[s]) begin
               r[s*FW +: FW] = FW'(sa) * FW'(sb);
            end else begin
               for (int j = 0; j < 2; j++) begin
                  r[s*FW + j*HW +: HW] = HW'(sa[j*QW +: QW]) * HW'(sb[j*QW +: QW]);
               end
            end
         end
      end
      return r;
   endfunction

   task automatic apply_chk(input logic [FW-1:0] a, input logic [FW-1:0] b,
                            input logic sp, input logic [1:0] q, input string req);
      logic [PW-1:0] exp;
      @(negedge clk);
      opa = a; opb = b; cfg_split = sp; cfg_quarter = q;
      exp = ref_prod(a, b, sp, q);
      @(posedge clk);
      #1;
      n_chk++;
      if (prod !== exp) begin
         n_bad++;
         $display("FAIL %s: split=%0b quarter=%b got %h expected %h", req, sp, q, prod, exp);
      end
   endtask

   task automatic whole_ignore_chk(input logic [FW-1:0] a, input logic [FW-1:0] b);
      logic [PW-1:0] base;
      apply_chk(a, b, 1'b0, 2'b00, "R1");
      base = prod;
      for (int q = 1; q < 4; q++) begin
         @(negedge clk);
         cfg_quarter = 2'(q);
         @(posedge clk);
         #1;
         n_chk++;
         if (prod !== base) begin
            n_bad++;
            $display("FAIL R2: quarter=%0d got %h expected %h", q, prod, base);
         end
      end
   endtask

   initial begin
      #100000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #1;
      n_chk++;
      if (prod !== '0) begin
         n_bad++;
         $display("FAIL R7: idle output got %h expected 0", prod);
      end

      // R6 R8-style boundary: all-ones in every configuration
      for (int c = 0; c < 8; c++)
         apply_chk('1, '1, c[2], c[1:0], "R6");
      // R7 zero operand in each configuration
      for (int c = 0; c < 8; c++)
         apply_chk('0, '1, c[2], c[1:0], "R7");
      // R3: one section loaded, other zero, in split modes
      for (int q = 0; q < 4; q++) begin
         apply_chk({18'h0, 18'h3FFFF}, {18'h0, 18'h3FFFF}, 1'b1, 2'(q), "R3");
         apply_chk({18'h3FFFF, 18'h0}, {18'h3FFFF, 18'h0}, 1'b1, 2'(q), "R3");
      end
      // R5 slice boundaries
      apply_chk({9'h1FF, 9'h0, 9'h1FF, 9'h0}, {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF}, 1'b1, 2'b11, "R5");
      // R4 top bits
      apply_chk({18'h20000, 18'h20000}, {18'h20001, 18'h3FFFF}, 1'b1, 2'b00, "R4");
      // R1 top bit of whole operands
      apply_chk(36'h800000000, 36'hFFFFFFFFF, 1'b0, 2'b00, "R1");
      // R2 quarter bits ignored in whole mode
      whole_ignore_chk('1, '1);
      whole_ignore_chk(36'h123456789, 36'hABCDEF012);

      for (int k = 0; k < 400; k++) begin
         logic [FW-1:0] ra, rb;
         logic [2:0] rc;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         rc = 3'($urandom);
         if (rc[2] == 1'b0)
            apply_chk(ra, rb, 1'b0, rc[1:0], "R1");
         else if (rc[1:0] == 2'b00)
            apply_chk(ra, rb, 1'b1, rc[1:0], "R4");
         else
            apply_chk(ra, rb, 1'b1, rc[1:0], "R5");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule